// File: doc/BRIEF.md
# Serial Command Loader for a Dual Stepper Bridge Controller

This block receives command words over a write-only three-wire serial link and turns them into the static control fields of four motor bridges, grouped as two motors of two bridges each. A host raises the chip select, clocks data bits in on the rising edge of the serial clock, and then pulses a strobe. Each bit enters a 16-bit holding register with the least significant bit arriving first. The strobe's rising edge copies the holding register into one of two 12-bit control registers, picked by the four address bits at the top of the word.

The serial inputs are asynchronous to the system clock. They pass through short synchronizers, and edges are detected in the system clock domain. Frames have no fixed length: any number of serial clocks may arrive while the chip select is high, and only the 16 most recent bits matter. When the strobe is tied high, a frame is committed by itself on its sixteenth bit. The four bridge outputs are decoded directly from the control registers. Each bridge has an enable, a direction (phase), a 3-bit current code and a decay-mode select.

Top module: `stepcmd_serial_if`

## Requirements
- R1: While reset is asserted, every bridge output (enable, phase, current code, decay) is zero, and it stays zero until a valid frame is committed.
- R2: Bits are taken on serial clock rising edges, least significant first, so the first of the last 16 bits becomes word bit 0.
- R3: Serial clock edges seen while chip select is low leave the holding register unchanged.
- R4: When more than 16 bits are clocked in, only the 16 most recent bits form the committed word.
- R5: Word bits 15..12 hold the address. Value 0 writes bits 11..0 into the motor-1 register, which drives bridges 0 and 1. Value 1 writes them into the motor-2 register, which drives bridges 2 and 3.
- R6: Within a register, bridge field k (k = 0 or 1) occupies bits 6k..6k+5. Inside a field, bit 0 is enable, bit 1 is phase, bits 4..2 are the current code and bit 5 is the decay select. Bridge n's current code appears on bridge_cur_o[3n+2:3n].
- R7: A rising edge of the strobe commits the holding register. No register changes without a commit, and a falling strobe commits nothing.
- R8: While the strobe is high, a commit happens on the 16th bit counted since chip select went high. The 17th and later bits cause no commit.
- R9: Chip select going low clears the bit count, so a fresh 16-bit frame after reselection auto-commits even if the previous frame was partial.
- R10: A frame may arrive in pieces, for example two 8-bit groups, with any idle time between them while chip select stays high.
- R11: A committed word whose address is neither 0 nor 1 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous; data taken on its rising edge |
| sdata_i | input | 1 | Serial data, least significant bit first |
| cs_i | input | 1 | Chip select, active high |
| strobe_i | input | 1 | Commit strobe; a rising edge commits, held high gives automatic commit |
| bridge_en_o | output | 4 | Enable per bridge (bit n = bridge n) |
| bridge_phase_o | output | 4 | Current direction per bridge |
| bridge_cur_o | output | 12 | 3-bit current code per bridge, bridge n at bits 3n+2..3n |
| bridge_decay_o | output | 4 | Decay select per bridge (0 slow, 1 mixed) |

## Verification
The assertions assume that each serial input level lasts at least several system clock cycles, so that every serial clock pulse gives exactly one synchronized rising edge. They also assume that data and chip select settle before the serial clock rises, and that the strobe never rises in the same synchronized cycle as a shift. The stimulus keeps to these rules: it changes one serial input at a time on the falling system clock and holds each level for four cycles. The reference model is therefore compared only once the pins have been quiet for six cycles, which is longer than the synchronizer, edge and commit latency.

// File: rtl/stepcmd_pkg.sv
// Shared widths and the per-bridge field type for the serial command loader.
// Assumes a fixed frame of address-over-payload with two bridges per motor.
package stepcmd_pkg;
    localparam int FRAME_W  = 16;
    localparam int ADDR_W   = 4;
    localparam int PAY_W    = FRAME_W - ADDR_W;
    localparam int MOTORS   = 2;
    localparam int BPM      = 2;
    localparam int NBR      = MOTORS * BPM;
    localparam int CUR_W    = 3;
    localparam int FIELD_W  = CUR_W + 3;

    // Bit order matches the payload field: en at bit 0, decay at the top.
    typedef struct packed {
        logic             decay;
        logic [CUR_W-1:0] cur;
        logic             phase;
        logic             en;
    } bridge_cfg_t;
endpackage

// File: rtl/stepcmd_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous level inputs.
// Assumes each input level is held much longer than STAGES clock cycles.
module stepcmd_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] pipe;

    // Shift the inputs through STAGES flops, clearing on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe[0] <= d_i;
            for (int k = 1; k < STAGES; k++) begin
                pipe[k] <= pipe[k-1];
            end
        end
    end

    assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/stepcmd_shifter.sv
// Holding shift register, bit counter and commit pulse generator.
// Assumes synchronized inputs; a commit pulse is raised one cycle after the
// strobe rises or after the FRAME_W-th bit while the strobe is held high.
module stepcmd_shifter #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_s,
    input  logic               sdata_s,
    input  logic               cs_s,
    input  logic               strobe_s,
    output logic [FRAME_W-1:0] word_o,
    output logic               commit_o
);
    localparam int CNT_W = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

    logic               sclk_q;
    logic               strobe_q;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   cnt;
    logic               commit_q;
    logic               shift_en;
    logic               strobe_rise;
    logic               auto_hit;

    // Remember last synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q   <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            sclk_q   <= sclk_s;
            strobe_q <= strobe_s;
        end
    end

    assign shift_en    = sclk_s && !sclk_q && cs_s;
    assign strobe_rise = strobe_s && !strobe_q;
    assign auto_hit    = shift_en && strobe_s && (cnt == CNT_LAST);

    // Shift new bits in at the top so the oldest bit settles at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (shift_en) begin
            shreg <= {sdata_s, shreg[FRAME_W-1:1]};
        end
    end

    // Count bits since select, saturating past the frame length.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_s) begin
            cnt <= '0;
        end else if (shift_en && cnt != CNT_SAT) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Register the commit request so it aligns with the updated holding word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_q <= 1'b0;
        end else begin
            commit_q <= strobe_rise || auto_hit;
        end
    end

    assign word_o   = shreg;
    assign commit_o = commit_q;

    AST_NO_SHIFT_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> $stable(shreg)); // R3
    AST_LSB_FIRST_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (shreg[FRAME_W-1] == $past(sdata_s)) &&
                     (shreg[FRAME_W-2:0] == $past(shreg[FRAME_W-1:1]))); // R2
    AST_COUNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> (cnt == '0)); // R9
    AST_NO_AUTO_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && strobe_s && strobe_q && cnt != CNT_LAST) |=> !commit_o); // R8
endmodule

// File: rtl/stepcmd_regbank.sv
// Control registers, one per motor, loaded from the holding word on commit.
// Assumes the address sits in the top ADDR_W bits; unknown addresses are dropped.
module stepcmd_regbank #(
    parameter int FRAME_W = 16,
    parameter int ADDR_W  = 4,
    parameter int MOTORS  = 2
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     commit_i,
    input  logic [FRAME_W-1:0]                       word_i,
    output logic [MOTORS-1:0][FRAME_W-ADDR_W-1:0]    ctrl_o
);
    localparam int PAY_W = FRAME_W - ADDR_W;

    logic [ADDR_W-1:0]                 addr;
    logic [PAY_W-1:0]                  payload;
    logic [MOTORS-1:0][PAY_W-1:0]      ctrl_q;
    logic                              addr_known;

    assign addr       = word_i[FRAME_W-1 -: ADDR_W];
    assign payload    = word_i[PAY_W-1:0];
    assign addr_known = (addr < ADDR_W'(MOTORS));

    for (genvar m = 0; m < MOTORS; m++) begin : g_motor
        // Load this motor's register when the commit targets its address.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctrl_q[m] <= '0;
            end else if (commit_i && addr == ADDR_W'(m)) begin
                ctrl_q[m] <= payload;
            end
        end

        AST_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
            (commit_i && addr == ADDR_W'(m)) |=> (ctrl_q[m] == $past(payload))); // R5
    end

    assign ctrl_o = ctrl_q;

    AST_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(ctrl_q)); // R7
    AST_UNKNOWN_ADDR_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && !addr_known) |=> $stable(ctrl_q)); // R11
endmodule

// File: rtl/stepcmd_serial_if.sv
// Top of the serial command loader: synchronizes the serial pins, assembles
// frames, commits them to per-motor registers and decodes per-bridge fields.
// Assumes serial pin levels last several system clocks each.
module stepcmd_serial_if
    import stepcmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sclk_i,
    input  logic                 sdata_i,
    input  logic                 cs_i,
    input  logic                 strobe_i,
    output logic [NBR-1:0]       bridge_en_o,
    output logic [NBR-1:0]       bridge_phase_o,
    output logic [NBR*CUR_W-1:0] bridge_cur_o,
    output logic [NBR-1:0]       bridge_decay_o
);
    logic [3:0]                  pins_s;
    logic [FRAME_W-1:0]          word;
    logic                        commit;
    logic [MOTORS-1:0][PAY_W-1:0] ctrl;

    stepcmd_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({strobe_i, cs_i, sdata_i, sclk_i}),
        .q_o   (pins_s)
    );

    stepcmd_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (pins_s[0]),
        .sdata_s  (pins_s[1]),
        .cs_s     (pins_s[2]),
        .strobe_s (pins_s[3]),
        .word_o   (word),
        .commit_o (commit)
    );

    stepcmd_regbank #(.FRAME_W(FRAME_W), .ADDR_W(ADDR_W), .MOTORS(MOTORS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .word_i   (word),
        .ctrl_o   (ctrl)
    );

    for (genvar b = 0; b < NBR; b++) begin : g_bridge
        localparam int MOT = b / BPM;
        localparam int OFS = (b % BPM) * FIELD_W;
        bridge_cfg_t cfg;
        assign cfg = ctrl[MOT][OFS +: FIELD_W];
        assign bridge_en_o[b]              = cfg.en;
        assign bridge_phase_o[b]           = cfg.phase;
        assign bridge_cur_o[b*CUR_W +: CUR_W] = cfg.cur;
        assign bridge_decay_o[b]           = cfg.decay;
    end

    AST_RESET_CLEARS_ALL: assert property (@(posedge clk)
        !rst_n |=> (bridge_en_o == '0 && bridge_phase_o == '0 &&
                    bridge_cur_o == '0 && bridge_decay_o == '0)); // R1
endmodule

// File: tb/sim_stepcmd_serial_if.sv
// Bench: behavioural reference model (bit queue + counter) compared each clock
// once the serial pins have been quiet long enough for the design to settle.
module sim_stepcmd_serial_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_i = 1'b0;
    logic        sdata_i = 1'b0;
    logic        cs_i = 1'b0;
    logic        strobe_i = 1'b0;
    logic [3:0]  bridge_en_o;
    logic [3:0]  bridge_phase_o;
    logic [11:0] bridge_cur_o;
    logic [3:0]  bridge_decay_o;

    int          errors = 0;
    int          checks = 0;
    int          quiet = 0;
    bit          done = 1'b0;
    string       tag = "R1";

    logic        bitq[$];
    int          bit_cnt = 0;
    logic [11:0] exp_m[2];

    always #5 clk = ~clk;

    stepcmd_serial_if u0 (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .sdata_i(sdata_i),
        .cs_i(cs_i), .strobe_i(strobe_i), .bridge_en_o(bridge_en_o),
        .bridge_phase_o(bridge_phase_o), .bridge_cur_o(bridge_cur_o),
        .bridge_decay_o(bridge_decay_o)
    );

    function automatic logic [5:0] exp_field(input int b);
        return exp_m[b / 2][(b % 2) * 6 +: 6];
    endfunction

    task automatic compare(input string t);
        logic [3:0]  e_en, e_ph, e_dc;
        logic [11:0] e_cur;
        for (int b = 0; b < 4; b++) begin
            logic [5:0] f;
            f = exp_field(b);
            e_en[b] = f[0];
            e_ph[b] = f[1];
            e_cur[b*3 +: 3] = f[4:2];
            e_dc[b] = f[5];
        end
        checks++;
        if (bridge_en_o !== e_en || bridge_phase_o !== e_ph ||
            bridge_cur_o !== e_cur || bridge_decay_o !== e_dc) begin
            errors++;
            $display("FAIL %s en=%b/%b phase=%b/%b cur=%h/%h decay=%b/%b (actual/expected)",
                     t, bridge_en_o, e_en, bridge_phase_o, e_ph,
                     bridge_cur_o, e_cur, bridge_decay_o, e_dc);
        end
    endtask

    // Per-clock comparison against the model once the pins are quiet.
    always @(posedge clk) begin
        #2;
        if (quiet < 1000) quiet++;
        if (rst_n && quiet >= 6 && !done) compare(tag);
    end

    task automatic model_commit();
        logic [15:0] w;
        for (int i = 0; i < 16; i++) w[i] = bitq[i];
        if (w[15:12] == 4'd0) exp_m[0] = w[11:0];
        else if (w[15:12] == 4'd1) exp_m[1] = w[11:0];
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cs(input logic v);
        @(negedge clk);
        cs_i = v; quiet = 0;
        if (!v) bit_cnt = 0;
        wait_clk(4);
    endtask

    task automatic set_strobe(input logic v);
        @(negedge clk);
        if (v && !strobe_i) model_commit();
        strobe_i = v; quiet = 0;
        wait_clk(4);
    endtask

    task automatic shift_bit(input logic b);
        @(negedge clk);
        sdata_i = b; quiet = 0;
        wait_clk(4);
        sclk_i = 1'b1; quiet = 0;
        if (cs_i) begin
            bitq.push_back(b);
            void'(bitq.pop_front());
            bit_cnt++;
            if (strobe_i && bit_cnt == 16) model_commit();
        end
        wait_clk(4);
        sclk_i = 1'b0; quiet = 0;
        wait_clk(2);
    endtask

    task automatic send_bits(input logic [15:0] w, input int lo, input int hi);
        for (int i = lo; i <= hi; i++) shift_bit(w[i]);
    endtask

    task automatic pulse_strobe();
        set_strobe(1'b1);
        set_strobe(1'b0);
    endtask

    task automatic settle_check(input string t);
        tag = t;
        wait_clk(10);
        compare(t);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) bitq.push_back(1'b0);
        exp_m[0] = '0;
        exp_m[1] = '0;
        wait_clk(3);
        settle_check("R1 during reset");
        @(negedge clk);
        rst_n = 1'b1;
        settle_check("R1 after reset");

        // R2/R6: bridge0 en=1 ph=0 cur=5 decay=1, bridge1 en=0 ph=1 cur=3 decay=0
        set_cs(1'b1);
        tag = "R7 no commit before strobe";
        send_bits(16'h03B5, 0, 15);
        settle_check("R7 no commit before strobe");
        pulse_strobe();
        settle_check("R2 R6 motor1 fields");

        // R5: address 1 targets bridges 2 and 3
        tag = "R5";
        send_bits(16'h1C6A, 0, 15);
        pulse_strobe();
        settle_check("R5 motor2 write");

        // R11: unknown addresses leave everything alone
        tag = "R11";
        send_bits(16'h2FFF, 0, 15);
        pulse_strobe();
        settle_check("R11 address 2 ignored");
        send_bits(16'hF123, 0, 15);
        pulse_strobe();
        settle_check("R11 address 15 ignored");

        // R4: extra leading bits are pushed out
        tag = "R4";
        send_bits(16'h000F, 0, 3);
        send_bits(16'h0FFF, 0, 15);
        pulse_strobe();
        settle_check("R4 last 16 bits used");

        // R3: clocks with chip select low do not reach the holding register
        tag = "R3";
        send_bits(16'h0ABC, 0, 15);
        set_cs(1'b0);
        send_bits(16'h1000, 0, 15);
        set_cs(1'b1);
        pulse_strobe();
        settle_check("R3 deselected clocks ignored");

        // R8: strobe held high gives automatic commit at bit 16 only
        tag = "R8";
        set_strobe(1'b1);
        set_cs(1'b0);
        set_cs(1'b1);
        send_bits(16'h1321, 0, 15);
        settle_check("R8 auto commit at 16");
        send_bits(16'h000F, 0, 3);
        settle_check("R8 no commit past 16");

        // R9: reselection clears a partial count
        tag = "R9";
        set_cs(1'b0);
        set_cs(1'b1);
        send_bits(16'h1FFF, 0, 7);
        set_cs(1'b0);
        set_cs(1'b1);
        send_bits(16'h0246, 0, 7);
        settle_check("R9 no commit mid frame");
        send_bits(16'h0246, 8, 15);
        settle_check("R9 fresh frame commits");

        // R10: two 8-bit groups with a long gap; falling strobe commits nothing
        tag = "R10";
        set_strobe(1'b0);
        settle_check("R7 falling strobe no commit");
        send_bits(16'h1777, 0, 7);
        wait_clk(40);
        send_bits(16'h1777, 8, 15);
        pulse_strobe();
        settle_check("R10 split frame");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule